// File: doc/BRIEF.md
# Dual-Width Accumulator ALU with Condition Flags

This block is the arithmetic and logic unit of an accumulator-style processor core. Each accepted operation takes an accumulator value, a memory operand, a carry input and a 4-bit operation code. It produces a 16-bit result, four condition flags (negative n, overflow v, zero z, carry c), one write enable per flag, and a result write enable. A run-time width select (`narrow` = 1 for 8-bit work, 0 for 16-bit) moves the sign bit, the carry-out position and the zero test between the low byte and the full word. Decimal arithmetic, operand fetch and addressing belong to other blocks.

The datapath is split into three units: an adder unit (add, subtract, compare, increment, decrement), a bitwise unit (AND, OR, XOR, bit test, test-and-set, test-and-reset) and a shift unit (shift left, logical shift right, rotate left, rotate right, byte swap). The operation code selects one unit. A single output register holds the selected result. A two-state slot machine sequences the register. It sits in SLOT_IDLE after reset and moves to SLOT_LOADED on any cycle with `in_valid` high. It stays in SLOT_LOADED while `in_valid` stays high and returns to SLOT_IDLE on the first cycle with `in_valid` low. `out_valid` is high exactly in SLOT_LOADED.

Top module: `dual_width_alu`

## Requirements
- R1: Operation codes are ADD=0, SUB=1, CMP=2, AND=3, OR=4, XOR=5, SHL=6, SHR=7, ROL=8, ROR=9, INC=10, DEC=11, BIT=12, TSB=13, TRB=14, SWAP=15. An operation accepted with `in_valid` at one rising edge appears on the outputs with `out_valid` high after that edge. `out_valid` is low after any edge where `in_valid` was low. Reset clears `out_valid`, the result, all flags and all enables.
- R2: ADD produces A + M + carry_in over the active width. Carry is taken from bit 8 (8-bit) or bit 16 (16-bit). All four flag enables are high.
- R3: SUB produces A + ~M + carry_in over the active width, so carry out high means no borrow occurred. All four flag enables are high.
- R4: For ADD and SUB, v is set when both addends of the effective addition (A and M, or A and ~M) have the same sign and the result sign differs. Sign is bit 7 or bit 15.
- R5: CMP computes A − M and enables n, z and c only. z means A equals M and c means A ≥ M (unsigned). The result write enable is low and the result equals the accumulator input.
- R6: AND, OR, XOR, INC and DEC enable only n and z. n is the result sign and z is set when the active-width result is zero.
- R7: SHL and ROL move the old sign bit into c. SHL shifts in 0 at bit 0, and ROL shifts in carry_in there. n, z and c are enabled.
- R8: SHR and ROR move the old bit 0 into c. SHR shifts in 0 at the top, so n is always 0. ROR shifts carry_in into bit 7 (8-bit) or bit 15 (16-bit). n, z and c are enabled.
- R9: BIT with `imm_operand` high enables only z. Otherwise it enables n, v and z, with n = memory sign bit, v = the bit just below it, and z = ((A & M) over the active width is 0). The result write enable is low in both cases.
- R10: TSB writes M | A and TRB writes M & ~A. Both enable only z, which is set when (A & M) over the active width is zero.
- R11: SWAP outputs the accumulator with its two bytes exchanged in either width. n is bit 7 and z tests bits 7..0 of the new value. Only n and z are enabled.
- R12: In 8-bit mode every operation except SWAP passes accumulator bits 15..8 unchanged to result bits 15..8.
- R13: A flag whose enable is low is driven as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| narrow | input | 1 | 1 selects 8-bit width, 0 selects 16-bit |
| op | input | 4 | Operation code (see R1) |
| imm_operand | input | 1 | Memory operand came from an immediate (affects BIT) |
| acc | input | 16 | Accumulator operand |
| mem | input | 16 | Memory operand |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered result is valid |
| result | output | 16 | Registered result |
| result_we | output | 1 | Destination register should be written |
| flag_n | output | 1 | Negative flag value |
| flag_v | output | 1 | Overflow flag value |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value |
| wen_n | output | 1 | Update enable for n |
| wen_v | output | 1 | Update enable for v |
| wen_z | output | 1 | Update enable for z |
| wen_c | output | 1 | Update enable for c |

## Verification
The bench sends the values 0x00, 0x7F, 0x80 and 0xFF (8-bit) and 0x0000, 0x7FFF, 0x8000 and 0xFFFF (16-bit) through every operation, with both carry inputs and both settings of the immediate flag. A design that took carry or sign from the wrong bit for the active width would show a carry from 0xFF + 1 only in one width, or would flag overflow on 0x7F + 1 in 16-bit mode. A narrow-mode accumulator with a non-zero high byte catches a unit that clears or alters bits 15..8. A byte swap whose flags came from the full word would give a wrong z on 0x0012 and a wrong n on 0x80xx. A rotate that inserted carry at bit 15 in 8-bit mode, a compare that wrote back, a bit test that touched n or v with an immediate operand, and any stale disabled flag left high all produce mismatches against the bench's independent model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned HALF_W = 8;
    localparam int unsigned FULL_W = 2 * HALF_W;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_SHL  = 4'd6,
        OP_SHR  = 4'd7,
        OP_ROL  = 4'd8,
        OP_ROR  = 4'd9,
        OP_INC  = 4'd10,
        OP_DEC  = 4'd11,
        OP_BIT  = 4'd12,
        OP_TSB  = 4'd13,
        OP_TRB  = 4'd14,
        OP_SWAP = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } nvzc_t;

    typedef struct packed {
        logic [FULL_W-1:0] res;
        nvzc_t             flg;
        nvzc_t             wen;
        logic              rwe;
    } alu_out_t;

    // Sign bit of a value at the active width
    function automatic logic sign_at(input logic narrow, input logic [FULL_W-1:0] d);
        return narrow ? d[HALF_W-1] : d[FULL_W-1];
    endfunction

    // Zero test of a value at the active width
    function automatic logic zero_at(input logic narrow, input logic [FULL_W-1:0] d);
        return narrow ? (d[HALF_W-1:0] == '0) : (d == '0);
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
(
    input  logic              narrow,
    input  alu_op_e           op,
    input  logic [FULL_W-1:0] a,
    input  logic [FULL_W-1:0] m,
    input  logic              cin,
    output alu_out_t          o
);

    logic [FULL_W-1:0] addend;
    logic              ci;
    logic [HALF_W:0]   sum_lo;
    logic [FULL_W:0]   sum_hi;
    logic [FULL_W-1:0] r;
    logic              co;
    logic              sa, sb, sr;

    // Pick the second addend and carry for the shared adder
    always_comb begin
        unique case (op)
            OP_SUB: begin
                addend = ~m;
                ci     = cin;
            end
            OP_CMP: begin
                addend = ~m;
                ci     = 1'b1;
            end
            OP_INC: begin
                addend = '0;
                ci     = 1'b1;
            end
            OP_DEC: begin
                addend = '1;
                ci     = 1'b0;
            end
            default: begin
                addend = m;
                ci     = cin;
            end
        endcase
    end

    assign sum_lo = {1'b0, a[HALF_W-1:0]} + {1'b0, addend[HALF_W-1:0]} + (HALF_W+1)'(ci);
    assign sum_hi = {1'b0, a} + {1'b0, addend} + (FULL_W+1)'(ci);

    assign r  = narrow ? {a[FULL_W-1:HALF_W], sum_lo[HALF_W-1:0]} : sum_hi[FULL_W-1:0];
    assign co = narrow ? sum_lo[HALF_W] : sum_hi[FULL_W];
    assign sa = sign_at(narrow, a);
    assign sb = sign_at(narrow, addend);
    assign sr = sign_at(narrow, r);

    always_comb begin
        o.res   = r;
        o.rwe   = 1'b1;
        o.flg.n = sr;
        o.flg.z = zero_at(narrow, r);
        o.flg.c = co;
        o.flg.v = (sa == sb) && (sr != sa);
        unique case (op)
            OP_ADD, OP_SUB: o.wen = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
            OP_CMP: begin
                o.wen = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
                o.res = a;
                o.rwe = 1'b0;
            end
            default: o.wen = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
        endcase
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
(
    input  logic              narrow,
    input  alu_op_e           op,
    input  logic              imm,
    input  logic [FULL_W-1:0] a,
    input  logic [FULL_W-1:0] m,
    output alu_out_t          o
);

    logic [FULL_W-1:0] common;
    logic              overlap_zero;
    logic              m_next;

    assign common       = a & m;
    assign overlap_zero = zero_at(narrow, common);
    assign m_next       = narrow ? m[HALF_W-2] : m[FULL_W-2];

    always_comb begin
        o.res = common;
        o.rwe = 1'b1;
        o.flg = '0;
        o.wen = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
        unique case (op)
            OP_OR:  o.res = a | m;
            OP_XOR: o.res = a ^ m;
            OP_TSB: o.res = m | a;
            OP_TRB: o.res = m & ~a;
            default: o.res = common;
        endcase
        o.flg.n = sign_at(narrow, o.res);
        o.flg.z = zero_at(narrow, o.res);
        unique case (op)
            OP_TSB, OP_TRB: begin
                o.flg.z = overlap_zero;
                o.wen   = '{n: 1'b0, v: 1'b0, z: 1'b1, c: 1'b0};
            end
            OP_BIT: begin
                o.res   = a;
                o.rwe   = 1'b0;
                o.flg.n = sign_at(narrow, m);
                o.flg.v = m_next;
                o.flg.z = overlap_zero;
                o.wen   = imm ? '{n: 1'b0, v: 1'b0, z: 1'b1, c: 1'b0}
                              : '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
(
    input  logic              narrow,
    input  alu_op_e           op,
    input  logic [FULL_W-1:0] a,
    input  logic              cin,
    output alu_out_t          o
);

    logic              fill;
    logic [FULL_W-1:0] left_r, right_r, swap_r;

    assign fill    = ((op == OP_ROL) || (op == OP_ROR)) ? cin : 1'b0;
    assign left_r  = narrow ? {a[FULL_W-1:HALF_W], a[HALF_W-2:0], fill}
                            : {a[FULL_W-2:0], fill};
    assign right_r = narrow ? {a[FULL_W-1:HALF_W], fill, a[HALF_W-1:1]}
                            : {fill, a[FULL_W-1:1]};
    assign swap_r  = {a[HALF_W-1:0], a[FULL_W-1:HALF_W]};

    always_comb begin
        o.rwe = 1'b1;
        o.flg = '0;
        o.wen = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
        unique case (op)
            OP_SHL, OP_ROL: begin
                o.res   = left_r;
                o.flg.c = sign_at(narrow, a);
            end
            OP_SWAP: begin
                o.res   = swap_r;
                o.wen.c = 1'b0;
            end
            default: begin
                o.res   = right_r;
                o.flg.c = a[0];
            end
        endcase
        if (op == OP_SWAP) begin
            o.flg.n = o.res[HALF_W-1];
            o.flg.z = (o.res[HALF_W-1:0] == '0);
        end else begin
            o.flg.n = sign_at(narrow, o.res);
            o.flg.z = zero_at(narrow, o.res);
        end
    end

endmodule

// File: rtl/dual_width_alu.sv
module dual_width_alu
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              narrow,
    input  logic [3:0]        op,
    input  logic              imm_operand,
    input  logic [15:0]       acc,
    input  logic [15:0]       mem,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [15:0]       result,
    output logic              result_we,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_c,
    output logic              wen_n,
    output logic              wen_v,
    output logic              wen_z,
    output logic              wen_c
);

    typedef enum logic {SLOT_IDLE, SLOT_LOADED} slot_e;

    slot_e    slot_q;
    alu_op_e  op_e;
    alu_out_t arith_o, bitw_o, shift_o, sel_o, next_o, out_q;

    assign op_e = alu_op_e'(op);

    alu_arith u_arith (
        .narrow (narrow),
        .op     (op_e),
        .a      (acc),
        .m      (mem),
        .cin    (carry_in),
        .o      (arith_o)
    );

    alu_bitwise u_bitwise (
        .narrow (narrow),
        .op     (op_e),
        .imm    (imm_operand),
        .a      (acc),
        .m      (mem),
        .o      (bitw_o)
    );

    alu_shift u_shift (
        .narrow (narrow),
        .op     (op_e),
        .a      (acc),
        .cin    (carry_in),
        .o      (shift_o)
    );

    // Unit select by operation class
    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB, OP_CMP, OP_INC, OP_DEC:          sel_o = arith_o;
            OP_AND, OP_OR, OP_XOR, OP_BIT, OP_TSB, OP_TRB:   sel_o = bitw_o;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_SWAP:         sel_o = shift_o;
            default:                                         sel_o = arith_o;
        endcase
    end

    // High-byte pass-through in 8-bit mode, disabled flags forced low
    always_comb begin
        next_o = sel_o;
        if (narrow && (op_e != OP_SWAP))
            next_o.res = {acc[FULL_W-1:HALF_W], sel_o.res[HALF_W-1:0]};
        next_o.flg = nvzc_t'(sel_o.flg & sel_o.wen);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slot_q <= SLOT_IDLE;
        else
            slot_q <= in_valid ? SLOT_LOADED : SLOT_IDLE;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else if (in_valid)
            out_q <= next_o;
    end

    assign out_valid = (slot_q == SLOT_LOADED);
    assign result    = out_q.res;
    assign result_we = out_q.rwe;
    assign flag_n    = out_q.flg.n;
    assign flag_v    = out_q.flg.v;
    assign flag_z    = out_q.flg.z;
    assign flag_c    = out_q.flg.c;
    assign wen_n     = out_q.wen.n;
    assign wen_v     = out_q.wen.v;
    assign wen_z     = out_q.wen.z;
    assign wen_c     = out_q.wen.c;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_e == OP_CMP) |=> !result_we && (result == $past(acc))); // R5
    AST_NZ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_e inside {OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC}) |=> !wen_v && !wen_c); // R6
    AST_SHR_CLEARS_N: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_e == OP_SHR) |=> wen_n && !flag_n); // R8
    AST_BIT_IMM_Z_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_e == OP_BIT) && imm_operand |=> wen_z && !wen_n && !wen_v && !wen_c && !result_we); // R9
    AST_SWAP_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_e == OP_SWAP) |=> result == {$past(acc[7:0]), $past(acc[15:8])}); // R11
    AST_NARROW_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && narrow && (op_e != OP_SWAP) |=> result[15:8] == $past(acc[15:8])); // R12
    AST_SWAP_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_e == OP_SWAP) |=> !wen_c && !flag_c && !wen_v && !flag_v); // R13

endmodule

// File: tb/test_dual_width_alu.sv
`timescale 1ns/1ps
module test_dual_width_alu;

    typedef struct packed {
        logic [15:0] res;
        logic [3:0]  flg;
        logic [3:0]  wen;
        logic        rwe;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        narrow = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        imm_operand = 1'b0;
    logic [15:0] acc = 16'h0;
    logic [15:0] mem = 16'h0;
    logic        carry_in = 1'b0;
    logic        out_valid, result_we;
    logic [15:0] result;
    logic        flag_n, flag_v, flag_z, flag_c;
    logic        wen_n, wen_v, wen_z, wen_c;

    int checks = 0;
    int errors = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    dual_width_alu i_dual_width_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .narrow(narrow), .op(op),
        .imm_operand(imm_operand), .acc(acc), .mem(mem), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .result_we(result_we),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .wen_n(wen_n), .wen_v(wen_v), .wen_z(wen_z), .wen_c(wen_c)
    );

    // Reference model written from the requirements
    function automatic exp_t model(input int opc, input bit nar, input bit imm,
                                   input int a, input int m, input int c);
        int w, mask, hb, av, mv, nm, r, s, res;
        bit fn, fv, fz, fc, rwe;
        bit [3:0] en;
        exp_t e;
        w = nar ? 8 : 16;
        mask = (1 << w) - 1;
        hb = w - 1;
        av = a & mask;
        mv = m & mask;
        nm = (~m) & mask;
        r = 0; s = 0;
        fn = 0; fv = 0; fz = 0; fc = 0; rwe = 1; en = 4'b0000;
        case (opc)
            0: begin s = av + mv + c; r = s & mask; fc = bit'((s >> w) & 1);
                     fv = bit'((((~(av ^ mv)) & (av ^ r)) >> hb) & 1); en = 4'b1111; end
            1: begin s = av + nm + c; r = s & mask; fc = bit'((s >> w) & 1);
                     fv = bit'((((~(av ^ nm)) & (av ^ r)) >> hb) & 1); en = 4'b1111; end
            2: begin s = av + nm + 1; r = s & mask; fc = bit'((s >> w) & 1);
                     en = 4'b1011; rwe = 0; end
            3: begin r = av & mv; en = 4'b1010; end
            4: begin r = av | mv; en = 4'b1010; end
            5: begin r = av ^ mv; en = 4'b1010; end
            6: begin r = (av << 1) & mask; fc = bit'((av >> hb) & 1); en = 4'b1011; end
            7: begin r = av >> 1; fc = bit'(av & 1); en = 4'b1011; end
            8: begin r = ((av << 1) | c) & mask; fc = bit'((av >> hb) & 1); en = 4'b1011; end
            9: begin r = (av >> 1) | (c << hb); fc = bit'(av & 1); en = 4'b1011; end
            10: begin r = (av + 1) & mask; en = 4'b1010; end
            11: begin r = (av - 1) & mask; en = 4'b1010; end
            12: begin
                rwe = 0;
                fz = ((av & mv) == 0);
                fn = bit'((mv >> hb) & 1);
                fv = bit'((mv >> (hb - 1)) & 1);
                en = imm ? 4'b0010 : 4'b1110;
            end
            13: begin r = mv | av; fz = ((av & mv) == 0); en = 4'b0010; end
            14: begin r = mv & (~av) & mask; fz = ((av & mv) == 0); en = 4'b0010; end
            default: begin
                r = ((a & 255) << 8) | ((a >> 8) & 255);
                fn = bit'((r >> 7) & 1);
                fz = ((r & 255) == 0);
                en = 4'b1010;
            end
        endcase
        if (opc < 12) begin
            fn = bit'((r >> hb) & 1);
            fz = (r == 0);
        end
        if (opc == 2 || opc == 12) res = a;
        else if (opc == 15) res = r;
        else res = nar ? ((a & 'hFF00) | r) : r;
        e.res = 16'(res);
        e.flg = {fn, fv, fz, fc} & en;
        e.wen = en;
        e.rwe = rwe;
        return e;
    endfunction

    function automatic string tag_of(input int opc);
        case (opc)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3, 4, 5, 10, 11: return "R6";
            6, 8: return "R7";
            7, 9: return "R8";
            12: return "R9";
            13, 14: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Driver: present one operation and push its expectation
    task automatic push(input int opc, input bit nar, input bit imm,
                        input logic [15:0] a, input logic [15:0] m, input bit c,
                        input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op = 4'(opc);
        narrow = nar;
        imm_operand = imm;
        acc = a;
        mem = m;
        carry_in = c;
        exp_q.push_back(model(opc, nar, imm, int'(a), int'(m), int'(c)));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each registered output with the scoreboard head
    always begin
        @(posedge clk);
        #1;
        if (rst_n) begin
            if (out_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R1 unexpected out_valid: actual=1 expected=0");
                end else begin
                    exp_t  e;
                    exp_t  got;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    got = {result, flag_n, flag_v, flag_z, flag_c, wen_n, wen_v, wen_z, wen_c, result_we};
                    if (got !== e) begin
                        errors++;
                        $display("FAIL %s res/nvzc/wen/we actual=%h/%b/%b/%b expected=%h/%b/%b/%b",
                                 t, got.res, got.flg, got.wen, got.rwe, e.res, e.flg, e.wen, e.rwe);
                    end
                end
            end else if (exp_q.size() != 0) begin
                string t;
                checks++;
                errors++;
                void'(exp_q.pop_front());
                t = tag_q.pop_front();
                $display("FAIL R1 (%s) missing out_valid: actual=0 expected=1", t);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  c8 [4];
        logic [15:0] c16 [4];
        c8  = '{8'h00, 8'h7F, 8'h80, 8'hFF};
        c16 = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};

        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || result !== 16'h0 || result_we !== 1'b0 ||
            {flag_n, flag_v, flag_z, flag_c, wen_n, wen_v, wen_z, wen_c} !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset: actual=%b/%h expected=0/0000", out_valid, result);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed boundaries
        push(0, 1, 0, 16'h007F, 16'h0001, 0, "R4");    // 8-bit overflow
        push(0, 0, 0, 16'h007F, 16'h0001, 0, "R4");    // no overflow at 16 bits
        push(1, 0, 0, 16'h8000, 16'h0001, 1, "R4");    // 16-bit negative overflow
        push(0, 1, 0, 16'h00FF, 16'h0001, 0, "R2");    // carry from bit 8
        push(0, 0, 0, 16'hFFFF, 16'h0001, 0, "R2");    // carry from bit 16
        push(1, 1, 0, 16'h0005, 16'h0007, 1, "R3");    // borrow -> carry low
        push(2, 1, 0, 16'h1242, 16'h0042, 0, "R5");    // equal
        push(9, 1, 0, 16'h0002, 16'h0000, 1, "R8");    // carry into bit 7
        push(9, 0, 0, 16'h0002, 16'h0000, 1, "R8");    // carry into bit 15
        push(8, 1, 0, 16'h0080, 16'h0000, 1, "R7");
        push(12, 0, 1, 16'h0000, 16'hC000, 0, "R9");   // immediate: z only
        push(12, 0, 0, 16'h0000, 16'hC000, 0, "R9");
        push(15, 0, 0, 16'h0012, 16'h0000, 0, "R11");  // low byte of new value zero
        push(15, 1, 0, 16'h8034, 16'h0000, 0, "R11");
        push(13, 1, 0, 16'hA50F, 16'h3CF0, 0, "R12"); // high byte passes
        push(3, 1, 0, 16'h5A00, 16'h0000, 1, "R13");   // carry_in high, c disabled
        idle();
        idle();   // gap exercises R1 return to idle

        // Corner sweep in both widths
        for (int o = 0; o < 16; o++)
            for (int nar = 0; nar < 2; nar++)
                for (int i = 0; i < 4; i++)
                    for (int j = 0; j < 4; j++)
                        for (int k = 0; k < 4; k++) begin
                            logic [15:0] a;
                            logic [15:0] m;
                            a = (nar != 0) ? {8'hA5, c8[i]} : c16[i];
                            m = (nar != 0) ? {8'h3C, c8[j]} : c16[j];
                            push(o, bit'(nar), bit'(k >> 1), a, m, bit'(k & 1), tag_of(o));
                        end
        idle();

        // Random operands
        for (int n = 0; n < 3000; n++) begin
            int o;
            o = int'($urandom_range(15, 0));
            push(o, bit'($urandom), bit'($urandom), 16'($urandom), 16'($urandom),
                 bit'($urandom), tag_of(o));
        end
        idle();
        repeat (4) @(negedge clk);

        // R1: every pushed item was produced
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1 leftover items: actual=%0d expected=0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule